// File: doc/BRIEF.md
# Maskable BCD Calendar Alarm Comparator

This unit watches a running calendar (seconds, minutes, hours, day of month and weekday, all in BCD) and compares it with a programmed 32-bit alarm word. It makes the comparison on each 1 Hz calendar update strobe. Every field of the alarm word has its own mask bit that takes the field out of the comparison. The day field is read as a weekday or as a day of month, chosen by a selector bit. When every unmasked field matches while the alarm is enabled, the unit sets a sticky alarm flag. An interrupt line follows that flag, gated by an interrupt enable.

Software may change the alarm word only while the alarm is disabled and a write-permit indication is high. That indication rises a fixed number of clock cycles after the enable drops. A parameter selects how the flag is cleared: either by writing zero to the flag bit through a status write strobe, or by writing one to a dedicated clear strobe.

Top module: `alarm_match_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `alarm_word` is 0, `alarm_flag` and `alarm_irq` are 0, and `wr_ok` is 0.
- R2: `wr_ok` goes high WF_DELAY (default 2) rising edges after `alm_en` is sampled low. It goes low on the first rising edge at which `alm_en` is sampled high.
- R3: A write on `alm_we` loads `reg_wdata` into `alarm_word` only when `alm_en` is 0 and `wr_ok` is 1 at that edge. Any other write leaves `alarm_word` unchanged.
- R4: Alarm word layout:
  - seconds BCD in bits 6:0, seconds mask in bit 7;
  - minutes BCD in bits 14:8, minutes mask in bit 15;
  - hours BCD in bits 21:16, PM bit 22, hours mask in bit 23;
  - day in bits 29:24, weekday select in bit 30, day mask in bit 31.

  When `cal_tick` is 1 and `alm_en` is 1 at an edge, and every unmasked field equals the calendar, `alarm_flag` is 1 after that edge.
- R5: A mask bit at 1 removes its field from the comparison. With bit 31 set, the alarm matches on every day.
- R6: With bit 30 at 1, bits 27:24 are compared with `cal_wday` (1 to 7). With bit 30 at 0, bits 29:24 are compared with `cal_date`.
- R7: The PM bit (22) has no effect on the comparison (24-hour mode).
- R8: The flag is not set when `alm_en` is 0 or when `cal_tick` is 0, even if the calendar matches.
- R9: Once set, `alarm_flag` stays 1 until it is cleared as R11 or R12 describes.
- R10: `alarm_irq` is 1 exactly when `alarm_flag` is 1 and `irq_en` is 1.
- R11: With CLR_STYLE = write-zero, `sts_we` with `reg_wdata[8]` = 0 clears the flag. Writing 1 to bit 8 has no effect, and `clr_we` is ignored.
- R12: With CLR_STYLE = write-one, `clr_we` with `reg_wdata[0]` = 1 clears the flag, and `sts_we` is ignored.
- R13: If a match and a clear request fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_tick | input | 1 | One-cycle strobe: calendar value updated |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD, 24-hour |
| cal_date | input | 6 | Calendar day of month, BCD |
| cal_wday | input | 3 | Calendar weekday, 1 to 7 |
| alm_en | input | 1 | Alarm enable |
| irq_en | input | 1 | Interrupt enable |
| reg_wdata | input | 32 | Write data shared by all write strobes |
| alm_we | input | 1 | Alarm word write strobe |
| sts_we | input | 1 | Status write strobe (write-zero clear) |
| clr_we | input | 1 | Clear register write strobe (write-one clear) |
| wr_ok | output | 1 | Alarm word write permitted |
| alarm_word | output | 32 | Current alarm word |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The bench builds two copies of the block with WF_DELAY at its default of 2, one with CLR_STYLE set to write-zero and one set to write-one. Both copies receive the same stimulus. Each clear write therefore shows the selected clear path acting in one copy and the other path being ignored in the other copy, in the same cycle. The short delay makes the exact edge at which the write permit rises, and a write rejected just before it, easy to observe.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    typedef struct packed {
        logic       day_msk;
        logic       wd_sel;
        logic [5:0] day;
        logic       hr_msk;
        logic       pm;
        logic [5:0] hour;
        logic       min_msk;
        logic [6:0] min;
        logic       sec_msk;
        logic [6:0] sec;
    } alarm_word_t;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] date;
        logic [2:0] wday;
    } cal_t;

    typedef enum logic {
        CLR_WRITE_ZERO = 1'b0,
        CLR_WRITE_ONE  = 1'b1
    } clr_style_e;

    localparam int WORD_W   = $bits(alarm_word_t);
    localparam int FLAG_BIT = 8;
    localparam int CLR_BIT  = 0;

    function automatic logic field_ok(input logic msk, input logic eq);
        return msk | eq;
    endfunction

endpackage

// File: rtl/alarm_wr_gate.sv
module alarm_wr_gate
    import alarm_pkg::*;
#(
    parameter int WF_DELAY = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alm_en,
    input  logic                alm_we,
    input  logic [WORD_W-1:0]   wdata,
    output logic                wr_ok,
    output alarm_word_t         word_q
);
    localparam int CW = (WF_DELAY < 1) ? 1 : $clog2(WF_DELAY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WF_DELAY);

    logic [CW-1:0] dis_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_cnt <= '0;
        end else if (alm_en) begin
            dis_cnt <= '0;
        end else if (dis_cnt != LIMIT) begin
            dis_cnt <= dis_cnt + 1'b1;
        end
    end

    assign wr_ok = (dis_cnt == LIMIT) && (WF_DELAY > 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (alm_we && wr_ok && !alm_en) begin
            word_q <= alarm_word_t'(wdata);
        end
    end
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import alarm_pkg::*;
(
    input  alarm_word_t word,
    input  cal_t        cal,
    output logic        hit
);
    logic sec_eq, min_eq, hr_eq, day_eq;

    always_comb begin
        sec_eq = (word.sec == cal.sec);
        min_eq = (word.min == cal.min);
        hr_eq  = (word.hour == cal.hour);
        if (word.wd_sel) begin
            day_eq = (word.day[3:0] == {1'b0, cal.wday});
        end else begin
            day_eq = (word.day == cal.date);
        end
        hit = field_ok(word.sec_msk, sec_eq) &
              field_ok(word.min_msk, min_eq) &
              field_ok(word.hr_msk,  hr_eq)  &
              field_ok(word.day_msk, day_eq);
    end
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl
    import alarm_pkg::*;
#(
    parameter clr_style_e CLR_STYLE = CLR_WRITE_ZERO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_req,
    input  logic              sts_we,
    input  logic              clr_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              irq_en,
    output logic              flag,
    output logic              irq
);
    logic clr_req;

    generate
        if (CLR_STYLE == CLR_WRITE_ZERO) begin : g_wz
            assign clr_req = sts_we && !wdata[FLAG_BIT];
        end else begin : g_wo
            assign clr_req = clr_we && wdata[CLR_BIT];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= set_req | (flag & ~clr_req);
        end
    end

    assign irq = flag & irq_en;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_pkg::*;
#(
    parameter int         WF_DELAY  = 2,
    parameter clr_style_e CLR_STYLE = CLR_WRITE_ZERO
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cal_tick,
    input  logic [6:0]  cal_sec,
    input  logic [6:0]  cal_min,
    input  logic [5:0]  cal_hour,
    input  logic [5:0]  cal_date,
    input  logic [2:0]  cal_wday,
    input  logic        alm_en,
    input  logic        irq_en,
    input  logic [31:0] reg_wdata,
    input  logic        alm_we,
    input  logic        sts_we,
    input  logic        clr_we,
    output logic        wr_ok,
    output logic [31:0] alarm_word,
    output logic        alarm_flag,
    output logic        alarm_irq
);
    alarm_word_t word_q;
    cal_t        cal;
    logic        hit;
    logic        set_req;

    assign cal = '{sec: cal_sec, min: cal_min, hour: cal_hour,
                   date: cal_date, wday: cal_wday};

    alarm_wr_gate #(.WF_DELAY(WF_DELAY)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .alm_en (alm_en),
        .alm_we (alm_we),
        .wdata  (reg_wdata),
        .wr_ok  (wr_ok),
        .word_q (word_q)
    );

    alarm_field_cmp u_cmp (
        .word (word_q),
        .cal  (cal),
        .hit  (hit)
    );

    assign set_req = cal_tick && alm_en && hit;

    alarm_flag_ctl #(.CLR_STYLE(CLR_STYLE)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (set_req),
        .sts_we  (sts_we),
        .clr_we  (clr_we),
        .wdata   (reg_wdata),
        .irq_en  (irq_en),
        .flag    (alarm_flag),
        .irq     (alarm_irq)
    );

    assign alarm_word = word_q;
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
    import alarm_pkg::*;
#(
    parameter clr_style_e CLR_STYLE = CLR_WRITE_ZERO
) (
    input logic        clk,
    input logic        rst,
    input logic        cal_tick,
    input logic        alm_en,
    input logic [31:0] reg_wdata,
    input logic        alm_we,
    input logic        sts_we,
    input logic        clr_we,
    input logic        wr_ok,
    input logic [31:0] alarm_word,
    input logic        alarm_flag,
    input logic        alarm_irq
);
    logic clr_seen;
    assign clr_seen = (CLR_STYLE == CLR_WRITE_ZERO) ?
                      (sts_we && !reg_wdata[FLAG_BIT]) :
                      (clr_we && reg_wdata[CLR_BIT]);

    // R2
    wrok_drop_chk: assert property (@(posedge clk) disable iff (rst)
        alm_en |=> !wr_ok);

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(alm_we && wr_ok && !alm_en) |=> $stable(alarm_word));

    // R8
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!alarm_flag && !(cal_tick && alm_en)) |=> !alarm_flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !clr_seen) |=> alarm_flag);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> alarm_flag);
endmodule

bind alarm_match_unit alarm_match_chk #(.CLR_STYLE(CLR_STYLE)) u_alarm_chk (
    .clk        (clk),
    .rst        (rst),
    .cal_tick   (cal_tick),
    .alm_en     (alm_en),
    .reg_wdata  (reg_wdata),
    .alm_we     (alm_we),
    .sts_we     (sts_we),
    .clr_we     (clr_we),
    .wr_ok      (wr_ok),
    .alarm_word (alarm_word),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
);

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
    import alarm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cal_tick = 1'b0;
    logic [6:0]  cal_sec = '0;
    logic [6:0]  cal_min = '0;
    logic [5:0]  cal_hour = '0;
    logic [5:0]  cal_date = '0;
    logic [2:0]  cal_wday = '0;
    logic        alm_en = 1'b0;
    logic        irq_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        alm_we = 1'b0;
    logic        sts_we = 1'b0;
    logic        clr_we = 1'b0;

    logic        wr_ok_a, wr_ok_b;
    logic [31:0] word_a, word_b;
    logic        flag_a, flag_b, irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alarm_match_unit #(.WF_DELAY(2), .CLR_STYLE(CLR_WRITE_ZERO)) i_alarm_match_unit (
        .clk(clk), .rst(rst), .cal_tick(cal_tick), .cal_sec(cal_sec),
        .cal_min(cal_min), .cal_hour(cal_hour), .cal_date(cal_date),
        .cal_wday(cal_wday), .alm_en(alm_en), .irq_en(irq_en),
        .reg_wdata(reg_wdata), .alm_we(alm_we), .sts_we(sts_we),
        .clr_we(clr_we), .wr_ok(wr_ok_a), .alarm_word(word_a),
        .alarm_flag(flag_a), .alarm_irq(irq_a)
    );

    alarm_match_unit #(.WF_DELAY(2), .CLR_STYLE(CLR_WRITE_ONE)) i_alarm_match_unit_w1c (
        .clk(clk), .rst(rst), .cal_tick(cal_tick), .cal_sec(cal_sec),
        .cal_min(cal_min), .cal_hour(cal_hour), .cal_date(cal_date),
        .cal_wday(cal_wday), .alm_en(alm_en), .irq_en(irq_en),
        .reg_wdata(reg_wdata), .alm_we(alm_we), .sts_we(sts_we),
        .clr_we(clr_we), .wr_ok(wr_ok_b), .alarm_word(word_b),
        .alarm_flag(flag_b), .alarm_irq(irq_b)
    );

    // {word, sec, min, hour, date, wday, expected flag}
    localparam int NV = 10;
    localparam logic [61:0] VEC [NV] = '{
        {32'h05121530, 7'h30, 7'h15, 6'h12, 6'h05, 3'd3, 1'b1}, // R4 full match
        {32'h05121530, 7'h31, 7'h15, 6'h12, 6'h05, 3'd3, 1'b0}, // R4 sec differs
        {32'h051215B0, 7'h59, 7'h15, 6'h12, 6'h05, 3'd3, 1'b1}, // R5 sec masked
        {32'h85121530, 7'h30, 7'h15, 6'h12, 6'h17, 3'd6, 1'b1}, // R5 day masked
        {32'h43121530, 7'h30, 7'h15, 6'h12, 6'h22, 3'd3, 1'b1}, // R6 weekday hit
        {32'h43121530, 7'h30, 7'h15, 6'h12, 6'h03, 3'd4, 1'b0}, // R6 weekday miss
        {32'h05521530, 7'h30, 7'h15, 6'h12, 6'h05, 3'd1, 1'b1}, // R7 PM ignored
        {32'h05921530, 7'h30, 7'h15, 6'h07, 6'h05, 3'd1, 1'b1}, // R5 hour masked
        {32'h05921530, 7'h30, 7'h16, 6'h07, 6'h05, 3'd1, 1'b0}, // R4 min differs
        {32'h05121530, 7'h30, 7'h15, 6'h12, 6'h06, 3'd5, 1'b0}  // R6 date miss
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        alm_en = 1'b0;
        repeat (3) @(negedge clk);
        reg_wdata = w;
        alm_we = 1'b1;
        @(negedge clk);
        alm_we = 1'b0;
    endtask

    task automatic clear_both();
        reg_wdata = 32'h0000_0001;
        sts_we = 1'b1;
        clr_we = 1'b1;
        @(negedge clk);
        sts_we = 1'b0;
        clr_we = 1'b0;
    endtask

    task automatic tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                        input logic [5:0] d, input logic [2:0] wd);
        cal_sec = s; cal_min = m; cal_hour = h; cal_date = d; cal_wday = wd;
        cal_tick = 1'b1;
        @(negedge clk);
        cal_tick = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 word", word_a, 32'h0);
        chk("R1 flag", {30'h0, flag_b, flag_a}, 32'h0);
        chk("R1 irq", {30'h0, irq_b, irq_a}, 32'h0);
        chk("R1 wr_ok", {31'h0, wr_ok_a}, 32'h0);
        rst = 1'b0;
        alm_en = 1'b1;
        @(negedge clk);
        chk("R1 wr_ok after reset", {31'h0, wr_ok_a}, 32'h0);

        // R2 handshake timing
        alm_en = 1'b0;
        @(negedge clk);
        chk("R2 wr_ok after 1 edge", {31'h0, wr_ok_a}, 32'h0);
        // R3 write before permit is rejected
        reg_wdata = 32'hDEADBEEF; alm_we = 1'b1;
        @(negedge clk);
        alm_we = 1'b0;
        chk("R3 write before wr_ok", word_a, 32'h0);
        chk("R2 wr_ok after 2 edges", {31'h0, wr_ok_a}, 32'h1);
        alm_en = 1'b1;
        @(negedge clk);
        chk("R2 wr_ok drops", {31'h0, wr_ok_a}, 32'h0);
        // R3 write while enabled is rejected
        reg_wdata = 32'h12345678; alm_we = 1'b1;
        @(negedge clk);
        alm_we = 1'b0;
        chk("R3 write while enabled", word_a, 32'h0);

        // Vector table: R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            write_word(VEC[i][61:30]);
            chk("R3 word loaded", word_a, VEC[i][61:30]);
            alm_en = 1'b1;
            clear_both();
            tick(VEC[i][29:23], VEC[i][22:16], VEC[i][15:10], VEC[i][9:4], VEC[i][3:1]);
            $display("vector %0d", i);
            chk("R4/R5/R6/R7 flag", {31'h0, flag_a}, {31'h0, VEC[i][0]});
            chk("R4/R5/R6/R7 flag w1c", {31'h0, flag_b}, {31'h0, VEC[i][0]});
        end

        // R8 disabled: no flag
        write_word(32'h05121530);
        clear_both();
        tick(7'h30, 7'h15, 6'h12, 6'h05, 3'd3);
        chk("R8 disabled", {31'h0, flag_a}, 32'h0);
        // R8 no tick: no flag
        alm_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 no tick", {31'h0, flag_a}, 32'h0);

        // R9 sticky, R10 irq
        tick(7'h30, 7'h15, 6'h12, 6'h05, 3'd3);
        chk("R10 irq off", {31'h0, irq_a}, 32'h0);
        irq_en = 1'b1;
        #1;
        chk("R10 irq on", {30'h0, irq_b, irq_a}, 32'h3);
        tick(7'h31, 7'h15, 6'h12, 6'h05, 3'd3);
        repeat (4) @(negedge clk);
        chk("R9 sticky", {30'h0, flag_b, flag_a}, 32'h3);

        // R11 / R12: write bit 8 = 1 on status -> no clear anywhere
        reg_wdata = 32'h0000_0100; sts_we = 1'b1;
        @(negedge clk);
        sts_we = 1'b0;
        chk("R11 status write one", {31'h0, flag_a}, 32'h1);
        chk("R12 status ignored", {31'h0, flag_b}, 32'h1);
        // status write zero: clears write-zero copy only
        reg_wdata = 32'h0000_0000; sts_we = 1'b1;
        @(negedge clk);
        sts_we = 1'b0;
        chk("R11 status write zero", {31'h0, flag_a}, 32'h0);
        chk("R12 status ignored", {31'h0, flag_b}, 32'h1);
        chk("R10 irq follows flag", {30'h0, irq_b, irq_a}, 32'h2);
        // re-arm write-zero copy, then write-one clear
        tick(7'h30, 7'h15, 6'h12, 6'h05, 3'd3);
        reg_wdata = 32'h0000_0001; clr_we = 1'b1;
        @(negedge clk);
        clr_we = 1'b0;
        chk("R11 clear reg ignored", {31'h0, flag_a}, 32'h1);
        chk("R12 clear reg one", {31'h0, flag_b}, 32'h0);

        // R13 set wins over same-cycle clear
        reg_wdata = 32'h0000_0001; sts_we = 1'b1; clr_we = 1'b1;
        tick(7'h30, 7'h15, 6'h12, 6'h05, 3'd3);
        sts_we = 1'b0; clr_we = 1'b0;
        chk("R13 set beats clear", {30'h0, flag_b, flag_a}, 32'h3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule